// File: doc/BRIEF.md
# Parallel Flash Program Sequencer

This controller sits on the host side of an asynchronous parallel NOR-style flash and writes one byte or word per request. A user hands it an address and a data value over a valid/ready pair. The controller then drives chip enable, write enable, output enable, the address bus and the data bus to carry out the device's two-write program sequence. After that it polls the device status until the internal write machine reports ready.

Once the device is ready, the controller can decode the status byte in a fixed order and return a 3-bit result code on a one-cycle done pulse. The user chooses how this works with three inputs:
- whether the status decode runs on every operation or only on the operation marked as last in a batch;
- whether polling re-issues the read-status command or only pulses output enable;
- whether the device is returned to read-array mode at the end.

On any error, the controller clears the device status before it reports done. The width of each strobe pulse is set by parameters, counted in clock cycles. The data bus is split into an output, an output enable and an input. The three-state pad is outside the block.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, all three strobes (`fl_ce_n`, `fl_we_n`, `fl_oe_n`) are high, `fl_dq_oe` is 0, `req_ready` is 1 and `done` is 0.
- R2: When a request is accepted, the first bus write carries command 0x40 to `req_addr`, and the second carries `req_data` to the same address. Every bus write of the operation uses that address. `req_ready` stays low until the operation ends.
- R3: With `poll_sel`=0, each poll is a bus write of 0x70 followed by one status read. Polling repeats while bit 7 of the status is 0.
- R4: With `poll_sel`=1, each poll is a status read only. Output enable goes high for one cycle between consecutive reads.
- R5: The status decode is applied to the read that shows bit 7 = 1. Status bit 3 gives code 1. Otherwise bit 1 gives code 2. Otherwise bit 4 gives code 3. When all three bits are clear, the code is 0.
- R6: With `chk_defer`=1, the decode runs only when `req_last`=1. Any other operation that completes reports code 5 (ready, not checked).
- R7: A result of code 1, 2, 3 or 4 causes a bus write of 0x50 before `done`.
- R8: When `req_last`=1, the final bus write of the operation is 0xFF.
- R9: If MAX_POLLS consecutive reads all show bit 7 = 0, the result is code 4 and no further reads are made. A ready flag seen on read number MAX_POLLS is still a normal completion.
- R10: `fl_dq_oe` is 1 only while `fl_we_n` is low, and never while `fl_oe_n` is low. Each write-enable pulse lasts WR_CYC cycles, and each output-enable pulse lasts RD_CYC cycles.
- R11: `done` is high for exactly one cycle, and `result` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Program request valid |
| req_ready | output | 1 | Controller idle, request accepted |
| req_addr | input | AW | Target address |
| req_data | input | DW | Value to program |
| req_last | input | 1 | Last operation of a batch: check (if deferred) and return to read array |
| chk_defer | input | 1 | 0: decode status every operation; 1: only on last |
| poll_sel | input | 1 | 0: poll with read-status command; 1: poll by output-enable pulses |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 voltage, 2 protect, 3 program, 4 timeout, 5 not checked |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | DW | Data driven to flash |
| fl_dq_oe | output | 1 | Drive enable for the data pad |
| fl_dq_i | input | DW | Data read from flash |

## Verification
The assertions assume that `req_valid` is a single-cycle pulse given only while `req_ready` is high. They also assume that `fl_dq_i` is stable at the end of each output-enable pulse. The bench's device model sets the status value on the edge where output enable falls and holds it for the whole pulse. The bench raises a request for exactly one cycle, and only after the previous `done` has been seen. Status values are chosen per operation so that every priority branch, the deferred path and the timeout boundary each appear at least once.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int WR_CYC    = 2,
  parameter int RD_CYC    = 2,
  parameter int MAX_POLLS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_last,
  input  logic          chk_defer,
  input  logic          poll_sel,
  output logic          done,
  output logic [2:0]    result,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i
);
  localparam int CW = $clog2(WR_CYC + RD_CYC + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_DATA, S_RSC, S_POLL, S_CLR, S_ARR, S_DONE} st_t;

  st_t           st, nxt;
  logic [CW-1:0] cnt, act_len;
  logic          rec;
  logic [AW-1:0] a_q;
  logic [DW-1:0] d_q;
  logic          last_q, defer_q, pm_q;
  logic [PW-1:0] polls;
  logic [7:0]    stat_q;
  logic [2:0]    code_c;
  logic          busop, is_wr, is_rd, tmo;

  assign busop     = (st != S_IDLE) && (st != S_DONE);
  assign is_rd     = (st == S_POLL);
  assign is_wr     = busop && !is_rd;
  assign req_ready = (st == S_IDLE);
  assign fl_ce_n   = !(busop && !rec);
  assign fl_we_n   = !(is_wr && !rec);
  assign fl_oe_n   = !(is_rd && !rec);
  assign fl_dq_oe  = is_wr && !rec;
  assign fl_addr   = a_q;
  assign act_len   = is_rd ? CW'(RD_CYC) : CW'(WR_CYC);
  assign tmo       = !stat_q[7] && (polls == PW'(MAX_POLLS - 1));

  always_comb begin
    case (st)
      S_SETUP: fl_dq_o = DW'(8'h40);
      S_DATA:  fl_dq_o = d_q;
      S_RSC:   fl_dq_o = DW'(8'h70);
      S_CLR:   fl_dq_o = DW'(8'h50);
      S_ARR:   fl_dq_o = DW'(8'hFF);
      default: fl_dq_o = '0;
    endcase
  end

  always_comb begin
    if (defer_q && !last_q) code_c = 3'd5;
    else if (stat_q[3])     code_c = 3'd1;
    else if (stat_q[1])     code_c = 3'd2;
    else if (stat_q[4])     code_c = 3'd3;
    else                    code_c = 3'd0;
  end

  always_comb begin
    case (st)
      S_SETUP: nxt = S_DATA;
      S_DATA:  nxt = pm_q ? S_POLL : S_RSC;
      S_RSC:   nxt = S_POLL;
      S_POLL:
        if (stat_q[7])
          nxt = (code_c inside {3'd1, 3'd2, 3'd3}) ? S_CLR : (last_q ? S_ARR : S_DONE);
        else if (tmo) nxt = S_CLR;
        else          nxt = pm_q ? S_POLL : S_RSC;
      S_CLR:   nxt = last_q ? S_ARR : S_DONE;
      S_ARR:   nxt = S_DONE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; rec <= 1'b0; a_q <= '0; d_q <= '0;
      last_q <= 1'b0; defer_q <= 1'b0; pm_q <= 1'b0; polls <= '0;
      stat_q <= '0; result <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q <= req_addr; d_q <= req_data; last_q <= req_last;
          defer_q <= chk_defer; pm_q <= poll_sel;
          polls <= '0; cnt <= '0; rec <= 1'b0; st <= S_SETUP;
        end
        S_DONE: begin done <= 1'b1; st <= S_IDLE; end
        default:
          if (!rec) begin
            if (cnt == act_len - CW'(1)) begin
              rec <= 1'b1; cnt <= '0;
              if (is_rd) stat_q <= fl_dq_i[7:0];
            end else cnt <= cnt + CW'(1);
          end else begin
            rec <= 1'b0;
            st  <= nxt;
            if (is_rd) begin
              if (stat_q[7]) result <= code_c;
              else if (tmo)  result <= 3'd4;
              else           polls  <= polls + PW'(1);
            end
          end
      endcase
    end
  end

  p_oe_hiz_r10:  assert property (@(posedge clk) disable iff (!rst_n) !fl_oe_n |-> !fl_dq_oe);
  p_drive_we_r10: assert property (@(posedge clk) disable iff (!rst_n) fl_dq_oe |-> !fl_we_n);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_code_range_r11: assert property (@(posedge clk) disable iff (!rst_n) done |-> result <= 3'd5);
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready);
  p_poll_bound_r9: assert property (@(posedge clk) disable iff (!rst_n) polls < PW'(MAX_POLLS));
endmodule

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;
  localparam int AW = 8, DW = 8, WR_CYC = 2, RD_CYC = 2, MAX_POLLS = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_last = 0, chk_defer = 0, poll_sel = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [2:0] result;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o, fl_dq_i;

  always #5 clk = ~clk;

  flash_prog_seq #(.AW(AW), .DW(DW), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .MAX_POLLS(MAX_POLLS)) u_flash_prog_seq (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_data, .req_last, .chk_defer,
    .poll_sel, .done, .result, .fl_ce_n, .fl_we_n, .fl_oe_n, .fl_addr, .fl_dq_o,
    .fl_dq_oe, .fl_dq_i);

  int n_chk = 0, n_fail = 0;
  int log_q[$];
  int addr_q[$];
  int busy_left = 0;
  logic [7:0] err_bits = 0;
  logic [7:0] stat_r = 0;
  logic prev_we = 1, prev_oe = 1;
  int we_w = 0, oe_w = 0;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;
  assign fl_dq_i = stat_r;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model and per-clock bus discipline
  always @(negedge clk) if (rst_n) begin
    if (!fl_oe_n && fl_dq_oe) begin n_fail++; $display("FAIL R10 dq driven with oe low actual=1 expected=0"); end
    if (fl_dq_oe && fl_we_n) begin n_fail++; $display("FAIL R10 dq driven with we high actual=1 expected=0"); end
    if (!fl_we_n) begin we_w++; wa = fl_addr; wd = fl_dq_o; end
    if (!fl_oe_n) oe_w++;
    if (!prev_we && fl_we_n) begin
      if (we_w != WR_CYC) begin n_fail++; $display("FAIL R10 we width actual=%0d expected=%0d", we_w, WR_CYC); end
      log_q.push_back(32'h100 | int'(wd)); addr_q.push_back(int'(wa)); we_w = 0;
    end
    if (prev_oe && !fl_oe_n) begin
      log_q.push_back(32'h200);
      stat_r = (busy_left > 0) ? 8'h00 : (8'h80 | err_bits);
      if (busy_left > 0) busy_left--;
    end
    if (!prev_oe && fl_oe_n) begin
      if (oe_w != RD_CYC) begin n_fail++; $display("FAIL R10 oe width actual=%0d expected=%0d", oe_w, RD_CYC); end
      oe_w = 0;
    end
    prev_we = fl_we_n; prev_oe = fl_oe_n;
  end

  task automatic run_op(input int addr, input int data, input bit last, input bit defer,
                        input bit psel, input int busy, input logic [7:0] errs, input string tag);
    int exp_q[$];
    int code;
    bit tmo = 0;
    int cyc;
    exp_q.push_back(32'h140); exp_q.push_back(32'h100 | data);
    for (int i = 0; i < MAX_POLLS; i++) begin
      if (!psel) exp_q.push_back(32'h170);
      exp_q.push_back(32'h200);
      if (i >= busy) break;
      if (i == MAX_POLLS - 1) tmo = 1;
    end
    if (tmo) code = 4;
    else if (defer && !last) code = 5;
    else if (errs[3]) code = 1;
    else if (errs[1]) code = 2;
    else if (errs[4]) code = 3;
    else code = 0;
    if (code >= 1 && code <= 4) exp_q.push_back(32'h150);
    if (last) exp_q.push_back(32'h1FF);
    log_q.delete(); addr_q.delete();
    busy_left = busy; err_bits = errs;
    @(negedge clk);
    req_addr = addr[AW-1:0]; req_data = data[DW-1:0]; req_last = last;
    chk_defer = defer; poll_sel = psel; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(req_ready == 0, {tag, " R2 busy"}, req_ready, 0);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check(done == 1, {tag, " R11 done seen"}, done, 1);
    check(result == code[2:0], {tag, " R5 R6 R7 R9 result"}, result, code);
    check(log_q.size() == exp_q.size(), {tag, " R2 R3 R4 R7 R8 bus op count"}, log_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
      check(log_q[i] == exp_q[i], {tag, " R2 R3 R4 R7 R8 bus op"}, log_q[i], exp_q[i]);
    foreach (addr_q[i]) check(addr_q[i] == addr, {tag, " R2 address"}, addr_q[i], addr);
    @(negedge clk);
    check(done == 0, {tag, " R11 single pulse"}, done, 0);
    check(req_ready == 1, {tag, " R2 ready again"}, req_ready, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes idle", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    check(fl_dq_oe == 0, "R1 dq released", fl_dq_oe, 0);
    check(req_ready == 1 && done == 0, "R1 ready/done", {req_ready, done}, 2);
    rst_n = 1;
    @(negedge clk);
    run_op(8'h12, 8'hA5, 0, 0, 0, 2, 8'h00, "cmd poll ok");
    run_op(8'h34, 8'h5A, 1, 0, 1, 1, 8'h00, "toggle poll last");
    run_op(8'h56, 8'h01, 0, 0, 0, 0, 8'h1A, "voltage priority");
    run_op(8'h78, 8'h02, 0, 0, 1, 0, 8'h12, "protect priority");
    run_op(8'h9A, 8'h03, 1, 0, 1, 1, 8'h10, "program error last");
    run_op(8'hBC, 8'h04, 0, 1, 1, 0, 8'h10, "deferred unchecked");
    run_op(8'hBD, 8'h05, 1, 1, 0, 0, 8'h10, "deferred last");
    run_op(8'hC0, 8'h06, 0, 0, 1, 100, 8'h00, "timeout R9");
    run_op(8'hC1, 8'h07, 0, 0, 0, MAX_POLLS - 1, 8'h00, "ready on last poll R9");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule